// File: doc/BRIEF.md
# Per-Lane Read-Event Counter Bank

This block holds one event counter for each requesting processor (a "lane"). Each lane watches a single-cycle strobe that pulses once for every cache read that processor makes, and its counter advances by one on each strobe while the lane is switched on. Software drives the bank through a plain single-cycle register port. One configuration word carries a switch-on bit and a clear bit for every lane, and a read-only count word per lane reports the count together with a sticky flag that shows the counter has hit its ceiling.

The usual software sequence for taking a sample is to switch the lane off, read its count word, pulse its clear bit high and then low, and switch it back on. While the lane is off the count word does not move, so the read is consistent. A build-time parameter selects a legacy arrangement in which the configuration word acts on all lanes at once. The register port has no handshake. Every write is taken in the cycle it is presented, and the read data follows the address combinationally. There is no back-pressure on either the strobes or the register port.

Top module: `evcnt_bank`

## Requirements
- R1: After reset the configuration word (offset 0x200) reads 0 and every count word reads 0.
- R2: The configuration word is at offset 0x200 and the count word of lane i is at offset 0x220 + 4*i. Any other offset reads 0. Writes to count words are ignored and leave the counts unchanged.
- R3: In standard mode, configuration bit i switches lane i on. A lane that is off keeps its count and flag exactly, whatever its strobe does, and switching one lane off does not affect the other lanes.
- R4: A count word holds the count in its low CNT_W bits (24 by default) and the saturation flag in bit 31. The bits between them read as 0.
- R5: In standard mode, configuration bit 16+i is the clear of lane i. While it is high, the count of lane i is held at 0, its flag is 0 and its strobes are ignored. Counting resumes once software writes the bit back to 0.
- R6: A count that has reached 2^CNT_W-1 stays there. A strobe that arrives while the lane is on and at that ceiling sets the flag. The flag then stays set until the lane is cleared, even while the lane is off.
- R7: When a configuration write and a strobe fall in the same cycle, the strobe is judged by the value being written. The write takes priority over the increment.
- R8: With LEGACY=1 only configuration bits 0 and 4 are stored, and all other written bits read back as 0. Bit 0 switches all lanes on, bit 4 clears all lanes, so writing 0x1, 0x10 and 0x0 means all-on, all-clear and all-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | NUM_LANES | One read-event pulse per lane per cycle |
| reg_wr | input | 1 | Register write strobe, taken in the same cycle |
| reg_addr | input | 12 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The in-RTL properties check the per-lane rules on every cycle: a clear forces the count and flag to zero, an idle lane holds its state, a count at the ceiling never wraps, the flag is sticky and only coexists with a full count, and count words never show padding bits. A behavioural model in the bench follows both a standard and a legacy instance cycle by cycle and compares the read data at every step. The bench's scenarios then show the properties no per-cycle check can: that the address decode is correct, that writes to count words are ignored, that a write and a strobe in the same cycle are resolved in favour of the write, and that the legacy bits act on all lanes at once.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int          REG_AW      = 12;
  localparam logic [11:0] CFG_OFS     = 12'h200;
  localparam logic [11:0] CNT_BASE    = 12'h220;
  localparam int          CLR_POS     = 16;
  localparam int          LEG_EN_BIT  = 0;
  localparam int          LEG_CLR_BIT = 4;
endpackage

// File: rtl/evb_cfg.sv
module evb_cfg
  import evb_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter bit LEGACY    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cfg,
  input  logic [31:0]          wdata,
  output logic [31:0]          cfg_q,
  output logic [NUM_LANES-1:0] lane_en,
  output logic [NUM_LANES-1:0] lane_clr
);
  localparam logic [31:0] LANE_ONES = 32'((64'd1 << NUM_LANES) - 64'd1);
  localparam logic [31:0] STD_MASK  = LANE_ONES | (LANE_ONES << CLR_POS);
  localparam logic [31:0] LEG_MASK  = (32'd1 << LEG_EN_BIT) | (32'd1 << LEG_CLR_BIT);
  localparam logic [31:0] WR_MASK   = LEGACY ? LEG_MASK : STD_MASK;

  logic [31:0] cfg_next;

  // a write in this cycle already governs this cycle's strobes
  assign cfg_next = wr_cfg ? (wdata & WR_MASK) : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_next;
  end

  generate
    if (LEGACY) begin : g_legacy
      assign lane_en  = {NUM_LANES{cfg_next[LEG_EN_BIT]}};
      assign lane_clr = {NUM_LANES{cfg_next[LEG_CLR_BIT]}};
    end else begin : g_std
      assign lane_en  = cfg_next[NUM_LANES-1:0];
      assign lane_clr = cfg_next[CLR_POS +: NUM_LANES];
    end
  endgenerate
endmodule

// File: rtl/evb_lane.sv
module evb_lane #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sat_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (en && evt) begin
      if (cnt_q == CNT_MAX) sat_q <= 1'b1;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !sat_q));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(cnt_q) && $stable(sat_q)));

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !clr) |=> sat_q);

  p_sat_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> cnt_q == CNT_MAX);
endmodule

// File: rtl/evb_rdmux.sv
module evb_rdmux
  import evb_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 24
) (
  input  logic [REG_AW-1:0]                 addr,
  input  logic [31:0]                       cfg_q,
  input  logic [NUM_LANES-1:0][CNT_W-1:0]   cnt,
  input  logic [NUM_LANES-1:0]              sat,
  output logic [31:0]                       rdata
);
  always_comb begin
    rdata = '0;
    if (addr == CFG_OFS) rdata = cfg_q;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (addr == CNT_BASE + 12'(4 * i)) begin
        rdata     = 32'(cnt[i]);
        rdata[31] = sat[i];
      end
    end
  end
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evb_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 24,
  parameter bit LEGACY    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] ev_strobe,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata
);
  localparam logic [31:0] PAD_MASK =
    32'h7FFF_FFFF & ~32'((64'd1 << CNT_W) - 64'd1);

  logic                             wr_cfg;
  logic [31:0]                      cfg_q;
  logic [NUM_LANES-1:0]             lane_en;
  logic [NUM_LANES-1:0]             lane_clr;
  logic [NUM_LANES-1:0][CNT_W-1:0]  cnt;
  logic [NUM_LANES-1:0]             sat;

  assign wr_cfg = reg_wr && (reg_addr == CFG_OFS);

  evb_cfg #(.NUM_LANES(NUM_LANES), .LEGACY(LEGACY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wdata(reg_wdata),
    .cfg_q(cfg_q), .lane_en(lane_en), .lane_clr(lane_clr)
  );

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      evb_lane #(.CNT_W(CNT_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .en(lane_en[g]), .clr(lane_clr[g]),
        .evt(ev_strobe[g]), .cnt_q(cnt[g]), .sat_q(sat[g])
      );
    end
  endgenerate

  evb_rdmux #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_rd (
    .addr(reg_addr), .cfg_q(cfg_q), .cnt(cnt), .sat(sat), .rdata(reg_rdata)
  );

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != CFG_OFS) |-> ((reg_rdata & PAD_MASK) == 32'd0));
endmodule

// File: tb/sim_evcnt_bank.sv
module sim_evcnt_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int CW   = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;

  int n_cmp = 0;
  int n_bad = 0;

  int          m_cnt [2][N];
  bit          m_sat [2][N];
  logic [31:0] m_cfg [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  evcnt_bank #(.NUM_LANES(N), .CNT_W(CW), .LEGACY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(evt), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd0));

  evcnt_bank #(.NUM_LANES(N), .CNT_W(CW), .LEGACY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(evt), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd1));

  function automatic logic [31:0] m_read(int k, logic [11:0] a);
    if (a == 12'h200) return m_cfg[k];
    for (int i = 0; i < N; i++)
      if (a == 12'h220 + 12'(4 * i))
        return {m_sat[k][i], 23'd0, 8'(m_cnt[k][i])};
    return 32'd0;
  endfunction

  task automatic m_update();
    for (int k = 0; k < 2; k++) begin
      logic [31:0] nc;
      nc = m_cfg[k];
      if (wr && addr == 12'h200)
        nc = (k == 1) ? (wdata & 32'h0000_0011) : (wdata & 32'h000F_000F);
      for (int i = 0; i < N; i++) begin
        bit en, cl;
        en = (k == 1) ? nc[0] : nc[i];
        cl = (k == 1) ? nc[4] : nc[16+i];
        if (cl) begin
          m_cnt[k][i] = 0;
          m_sat[k][i] = 1'b0;
        end else if (en && evt[i]) begin
          if (m_cnt[k][i] == MAXV) m_sat[k][i] = 1'b1;
          else                     m_cnt[k][i]++;
        end
      end
      m_cfg[k] = nc;
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [N-1:0] e, logic w, logic [11:0] a, logic [31:0] d);
    evt = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    m_update();
    @(negedge clk);
    chk("R4 model u0", rd0, m_read(0, addr));
    chk("R8 model u1", rd1, m_read(1, addr));
  endtask

  task automatic wcfg(logic [31:0] d);
    step('0, 1'b1, 12'h200, d);
  endtask

  task automatic look(logic [11:0] a);
    step('0, 1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_cfg[k] = '0;
      for (int i = 0; i < N; i++) begin m_cnt[k][i] = 0; m_sat[k][i] = 1'b0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    look(12'h200); chk("R1 cfg", rd0, 32'h0);
    look(12'h22C); chk("R1 lane3", rd0, 32'h0);

    // R3 lanes 0 and 2 on
    wcfg(32'h0000_0005);
    repeat (10) step(4'hF, 1'b0, 12'h220, 32'd0);
    look(12'h220); chk("R3 lane0", rd0, 32'd10);
    look(12'h224); chk("R3 lane1 off", rd0, 32'd0);
    look(12'h228); chk("R3 lane2", rd0, 32'd10);
    wcfg(32'h0000_0001);
    repeat (5) step(4'hF, 1'b0, 12'h228, 32'd0);
    look(12'h228); chk("R3 lane2 held", rd0, 32'd10);
    look(12'h220); chk("R3 lane0 other", rd0, 32'd15);

    // R2 decode and ignored writes
    look(12'h210); chk("R2 hole", rd0, 32'd0);
    step('0, 1'b1, 12'h220, 32'h55);
    look(12'h220); chk("R2 ro write", rd0, 32'd15);
    look(12'h200); chk("R2 cfg read", rd0, 32'h1);

    // R5 clear held high
    wcfg(32'h0001_0001);
    repeat (3) step(4'h1, 1'b0, 12'h220, 32'd0);
    look(12'h220); chk("R5 held zero", rd0, 32'd0);
    wcfg(32'h0000_0001);
    repeat (2) step(4'h1, 1'b0, 12'h220, 32'd0);
    look(12'h220); chk("R5 resume", rd0, 32'd2);

    // R6 saturation on lane1
    wcfg(32'h0000_0002);
    repeat (MAXV) step(4'h2, 1'b0, 12'h224, 32'd0);
    look(12'h224); chk("R6 at max", rd0, 32'h0000_00FF);
    step(4'h2, 1'b0, 12'h224, 32'd0);
    look(12'h224); chk("R4 flag bit31", rd0, 32'h8000_00FF);
    repeat (3) step(4'h2, 1'b0, 12'h224, 32'd0);
    wcfg(32'h0);
    look(12'h224); chk("R6 sticky", rd0, 32'h8000_00FF);
    wcfg(32'h0002_0000);
    wcfg(32'h0);
    look(12'h224); chk("R6 cleared", rd0, 32'h0);

    // R7 write wins over same-cycle strobe
    step(4'h8, 1'b1, 12'h200, 32'h0000_0008);
    look(12'h22C); chk("R7 on-write counts", rd0, 32'd1);
    step(4'h8, 1'b1, 12'h200, 32'h0);
    look(12'h22C); chk("R7 off-write drops", rd0, 32'd1);
    step(4'h8, 1'b1, 12'h200, 32'h0008_0008);
    look(12'h22C); chk("R7 clear-write", rd0, 32'd0);
    wcfg(32'h0);

    // R8 legacy instance
    wcfg(32'h0000_0010);
    look(12'h224); chk("R8 clear all", rd1, 32'd0);
    wcfg(32'h0000_0001);
    repeat (4) step(4'hA, 1'b0, 12'h224, 32'd0);
    look(12'h224); chk("R8 lane1", rd1, 32'd4);
    look(12'h220); chk("R8 lane0", rd1, 32'd0);
    wcfg(32'h0);
    repeat (3) step(4'hA, 1'b0, 12'h22C, 32'd0);
    look(12'h22C); chk("R8 all off", rd1, 32'd4);
    wcfg(32'hFFFF_FFFF);
    look(12'h200); chk("R8 cfg bits", rd1, 32'h0000_0011);
    look(12'h22C); chk("R8 clear wins", rd1, 32'd0);
    wcfg(32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule